// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is a write-only serial slave that loads a small bank of 10-bit configuration registers. There is no readback path. A host lowers an active-low select line and clocks a 16-bit frame in on a data line, most significant bit first. Each bit is taken on a rising edge of the serial clock. When the host raises the select line again, the block commits the frame. The frame holds a 4-bit address, two bits that the block ignores, and a 10-bit data word. The select line also gates the serial clock: only clock edges seen while select is low are counted and shifted.

All three serial pins are sampled in the system clock domain through two-flop synchronisers, and every later decision is taken in that domain. A commit needs at least 16 counted edges since select fell. If more bits arrive, only the last 16 shifted in are used. Select may stay low for any length of time before the first clock edge.

The register bank gives each colour channel (red, green, blue) an offset register and a gain register, and it adds a mode register whose bit 0 selects the gain range. All registers drive parallel outputs.

Top module: `cfg_serial_port`

## Requirements
- R1: A synchronous active-high `rst` clears every register output and `gain_range_sel` to zero.
- R2: A frame is 16 bits sent in this order: address bits 3 down to 0, then two ignored bits, then data bits 9 down to 0. On the rise of `ser_sel_n`, the data word is written to the register at the frame's address. The map is: 0 mode, 1 red offset, 2 green offset, 3 blue offset, 4 red gain, 5 green gain, 6 blue gain.
- R3: If fewer than 16 rising `ser_clk` edges are counted between the fall and the next rise of `ser_sel_n`, no register changes.
- R4: If more than 16 edges are counted, the last 16 bits shifted in before `ser_sel_n` rises form the frame.
- R5: A `ser_clk` rising edge is ignored while `ser_sel_n` is high. This includes an edge that arrives together with the rise of `ser_sel_n`.
- R6: The gain registers keep data bits 8..0. Data bit 9 is dropped, and the gain outputs are 9 bits wide.
- R7: `gain_range_sel` equals bit 0 of the mode register and is 0 after reset.
- R8: A frame addressed to 7 through 15 changes no register.
- R9: The time between the fall of `ser_sel_n` and the first `ser_clk` edge has no effect on the result.
- R10: A write changes only the addressed register. Every register holds its value until the next valid write to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_sel_n | input | 1 | Frame select, active low; its rise commits |
| ser_clk | input | 1 | Serial bit clock; each level held at least 3 `clk` periods |
| ser_dat | input | 1 | Serial data; changes only while `ser_clk` is low |
| mode_word | output | 10 | Mode register |
| gain_range_sel | output | 1 | Gain range select (mode bit 0) |
| offset_red | output | 10 | Red offset register |
| offset_green | output | 10 | Green offset register |
| offset_blue | output | 10 | Blue offset register |
| gain_red | output | 9 | Red gain register |
| gain_green | output | 9 | Green gain register |
| gain_blue | output | 9 | Blue gain register |

## Verification
Two events can fall in the same synchronised cycle: a serial clock edge being counted and the select rise that commits. The bench raises the final (16th) `ser_clk` edge at the same instant that `ser_sel_n` rises. Both pass through identical synchronisers, so the edge is gated off and the counter stays at 15. The bench judges the outcome by checking that every register output keeps its previous value.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int ADDR_W   = 4;
    localparam int PAD_W    = 2;
    localparam int DATA_W   = 10;
    localparam int FRAME_W  = ADDR_W + PAD_W + DATA_W;
    localparam int GAIN_W   = 9;
    localparam int NUM_REGS = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 4'd0,
        REG_OFS_R  = 4'd1,
        REG_OFS_G  = 4'd2,
        REG_OFS_B  = 4'd3,
        REG_GAIN_R = 4'd4,
        REG_GAIN_G = 4'd5,
        REG_GAIN_B = 4'd6
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PAD_W-1:0]  pad;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic bit is_gain_slot(int idx);
        return (idx >= int'(REG_GAIN_R)) && (idx <= int'(REG_GAIN_B));
    endfunction

    function automatic int slot_width(int idx);
        return is_gain_slot(idx) ? GAIN_W : DATA_W;
    endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
    parameter int          W        = 3,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgport_frame_rx.sv
module cfgport_frame_rx
    import cfgport_pkg::*;
#(
    parameter int FRM_W = FRAME_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sel_n_s,
    input  logic    sclk_s,
    input  logic    sdat_s,
    output wr_req_t req_o
);
    localparam int               CNT_W = $clog2(FRM_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRM_W);

    logic             sclk_d, sel_d;
    logic [CNT_W-1:0] cnt;
    logic [FRM_W-1:0] shift_q;
    frame_t           frm;

    wire sel_fall  = sel_d && !sel_n_s;
    wire sel_rise  = !sel_d && sel_n_s;
    wire bit_take  = !sel_n_s && sclk_s && !sclk_d;

    assign frm = frame_t'(shift_q[FRAME_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            sel_d   <= 1'b1;
            cnt     <= '0;
            shift_q <= '0;
            req_o   <= '0;
        end else begin
            sclk_d   <= sclk_s;
            sel_d    <= sel_n_s;
            req_o.wr <= 1'b0;
            if (sel_fall) begin
                cnt <= '0;
            end else if (bit_take) begin
                shift_q <= {shift_q[FRM_W-2:0], sdat_s};
                if (cnt != FULL) cnt <= cnt + 1'b1;
            end
            if (sel_rise && cnt == FULL) begin
                req_o.wr   <= 1'b1;
                req_o.addr <= frm.addr;
                req_o.data <= frm.data;
            end
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n_s |=> $stable(shift_q));

    // R3
    short_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && cnt != FULL) |=> !req_o.wr);
endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
    import cfgport_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req_i,
    output logic [DATA_W-1:0] regs_o [N_REGS]
);
    logic [N_REGS*DATA_W-1:0] flat;

    for (genvar i = 0; i < N_REGS; i++) begin : g_slot
        localparam int SW = slot_width(i);
        logic [SW-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (req_i.wr && req_i.addr == ADDR_W'(i))
                q <= req_i.data[SW-1:0];
        end

        assign regs_o[i] = DATA_W'(q);
        assign flat[i*DATA_W +: DATA_W] = regs_o[i];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flat == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i.wr |=> $stable(flat));

    // R8
    unmapped_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && int'(req_i.addr) >= N_REGS) |=> $stable(flat));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfgport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [DATA_W-1:0] mode_word,
    output logic              gain_range_sel,
    output logic [DATA_W-1:0] offset_red,
    output logic [DATA_W-1:0] offset_green,
    output logic [DATA_W-1:0] offset_blue,
    output logic [GAIN_W-1:0] gain_red,
    output logic [GAIN_W-1:0] gain_green,
    output logic [GAIN_W-1:0] gain_blue
);
    logic [2:0]        pins_s;
    wr_req_t           req;
    logic [DATA_W-1:0] regs [NUM_REGS];

    cfgport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_sel_n, ser_clk, ser_dat}),
        .sync_o  (pins_s)
    );

    cfgport_frame_rx #(.FRM_W(FRAME_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .sel_n_s (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .sdat_s  (pins_s[0]),
        .req_o   (req)
    );

    cfgport_regbank #(.N_REGS(NUM_REGS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .regs_o (regs)
    );

    assign mode_word      = regs[REG_MODE];
    assign gain_range_sel = regs[REG_MODE][0];
    assign offset_red     = regs[REG_OFS_R];
    assign offset_green   = regs[REG_OFS_G];
    assign offset_blue    = regs[REG_OFS_B];
    assign gain_red       = regs[REG_GAIN_R][GAIN_W-1:0];
    assign gain_green     = regs[REG_GAIN_G][GAIN_W-1:0];
    assign gain_blue      = regs[REG_GAIN_B][GAIN_W-1:0];

    // R7
    range_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(mode_word[0]) |-> (gain_range_sel == mode_word[0]));
endmodule

// File: tb/tb_cfg_serial_port.sv
`timescale 1ns/1ps
module tb_cfg_serial_port;
    logic clk = 1'b0, rst = 1'b1;
    logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [9:0] mode_word, offset_red, offset_green, offset_blue;
    logic       gain_range_sel;
    logic [8:0] gain_red, gain_green, gain_blue;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    logic [9:0] exp_q [7];

    always #5 clk = ~clk;

    cfg_serial_port dut (
        .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .mode_word(mode_word), .gain_range_sel(gain_range_sel),
        .offset_red(offset_red), .offset_green(offset_green), .offset_blue(offset_blue),
        .gain_red(gain_red), .gain_green(gain_green), .gain_blue(gain_blue)
    );

    function automatic logic [9:0] got(int k);
        case (k)
            0: return mode_word;
            1: return offset_red;
            2: return offset_green;
            3: return offset_blue;
            4: return {1'b0, gain_red};
            5: return {1'b0, gain_green};
            default: return {1'b0, gain_blue};
        endcase
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < 7; k++) begin
            vectors++;
            if (got(k) !== exp_q[k]) begin
                miscompares++;
                $display("FAIL %s reg%0d actual=%h expected=%h", req, k, got(k), exp_q[k]);
            end
        end
        vectors++;
        if (gain_range_sel !== exp_q[0][0]) begin
            miscompares++;
            $display("FAIL %s range_sel actual=%b expected=%b", req, gain_range_sel, exp_q[0][0]);
        end
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            #40 ser_clk = 1'b1;
            #40 ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [31:0] w, input int n, input int setup_ns);
        ser_sel_n = 1'b0;
        #(setup_ns);
        shift_bits(w, n);
        #40 ser_sel_n = 1'b1;
        #200;
    endtask

    function automatic logic [15:0] frm(input logic [3:0] a, input logic [1:0] pad, input logic [9:0] d);
        return {a, pad, d};
    endfunction

    task automatic t_reset();
        for (int k = 0; k < 7; k++) exp_q[k] = '0;
        check_all("R1/R7 reset");
    endtask

    task automatic t_basic();
        send({16'h0, frm(4'd1, 2'b00, 10'h2A5)}, 16, 40); exp_q[1] = 10'h2A5;
        send({16'h0, frm(4'd2, 2'b11, 10'h15A)}, 16, 40); exp_q[2] = 10'h15A;
        send({16'h0, frm(4'd3, 2'b01, 10'h3FF)}, 16, 40); exp_q[3] = 10'h3FF;
        check_all("R2/R10 offsets");
        send({16'h0, frm(4'd0, 2'b10, 10'h3FF)}, 16, 40); exp_q[0] = 10'h3FF;
        check_all("R7 mode set");
        send({16'h0, frm(4'd0, 2'b00, 10'h002)}, 16, 40); exp_q[0] = 10'h002;
        check_all("R7 mode clear bit0");
        send({16'h0, frm(4'd2, 2'b00, 10'h001)}, 16, 40); exp_q[2] = 10'h001;
        check_all("R10 overwrite green");
    endtask

    task automatic t_gain();
        send({16'h0, frm(4'd4, 2'b00, 10'h3AB)}, 16, 40); exp_q[4] = 10'h1AB;
        send({16'h0, frm(4'd5, 2'b00, 10'h1FF)}, 16, 40); exp_q[5] = 10'h1FF;
        send({16'h0, frm(4'd6, 2'b00, 10'h200)}, 16, 40); exp_q[6] = 10'h000;
        check_all("R6 gain width");
    endtask

    task automatic t_short();
        send({17'h0, frm(4'd1, 2'b00, 10'h0F0) >> 1}, 15, 40);
        check_all("R3 fifteen edges");
        send(32'h0, 0, 200);
        check_all("R3 zero edges");
    endtask

    task automatic t_long();
        send({12'h0, 4'hB, frm(4'd3, 2'b00, 10'h0C3)}, 20, 40); exp_q[3] = 10'h0C3;
        check_all("R4 twenty bits");
        send({frm(4'd1, 2'b00, 10'h111), frm(4'd5, 2'b00, 10'h0AA)}, 32, 40); exp_q[5] = 10'h0AA;
        check_all("R4 two frames back to back");
    endtask

    task automatic t_gate();
        logic [15:0] f;
        f = frm(4'd1, 2'b00, 10'h3C3);
        shift_bits({16'h0, f}, 16);
        #40 ser_sel_n = 1'b0;
        #200 ser_sel_n = 1'b1;
        #200;
        check_all("R5 ungated frame not counted");
        shift_bits({24'h0, f[15:8]}, 8);
        send({24'h0, f[7:0]}, 8, 40);
        check_all("R5 partial gated");
        ser_sel_n = 1'b0;
        #40 shift_bits({17'h0, f[15:1]}, 15);
        ser_dat = f[0];
        #40;
        ser_clk = 1'b1; ser_sel_n = 1'b1;
        #40 ser_clk = 1'b0;
        #200;
        check_all("R5 edge coincident with select rise");
    endtask

    task automatic t_unused();
        send({16'h0, frm(4'd7, 2'b00, 10'h3FF)}, 16, 40);
        send({16'h0, frm(4'd9, 2'b00, 10'h155)}, 16, 40);
        send({16'h0, frm(4'd15, 2'b11, 10'h2AA)}, 16, 40);
        check_all("R8 unmapped addresses");
    endtask

    task automatic t_setup();
        send({16'h0, frm(4'd6, 2'b00, 10'h0E7)}, 16, 8000); exp_q[6] = 10'h0E7;
        check_all("R9 long setup");
    endtask

    initial begin
        #2;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        #50;
        t_reset();
        t_basic();
        t_gain();
        t_short();
        t_long();
        t_gate();
        t_unused();
        t_setup();
        rst = 1'b1;
        #40 rst = 1'b0;
        #20;
        for (int k = 0; k < 7; k++) exp_q[k] = '0;
        check_all("R1 reset after writes");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule